// File: doc/BRIEF.md
# Multi-Port GPIO Register Bank

This block is a word-addressed register bank that sits on a simple two-phase peripheral bus (select, enable, write) and controls up to four general-purpose pin groups. Each group holds an output value register and a direction register. It also has a read-only view of its pins, taken through a two-stage synchronizer. A pin whose direction bit is set is driven from the output value register. A pin whose direction bit is clear is released, so its output value is held low and its output enable is off.

The output value and direction registers of successive groups are laid out 12 bytes apart, starting at offset 0x00. The synchronized pin views are packed 4 bytes apart, starting at 0x50. The range 0x30 to 0x4C belongs to a separate interrupt unit. The bank does not decode that range itself. It raises a select strobe for the interrupt unit and passes the unit's read data back onto the bus. The bus has no wait states. A write lands on the clock edge that ends the access phase, and read data is valid during the access phase.

Top module: `gpio_bank`

## Requirements
- R1: After reset every output value bit and every direction bit is 0. All output enables are low, all driven values are low, and the value and direction registers read back as 0.
- R2: A write in the access phase (select, enable and write all high) to offset 0x00 + 12*p stores the low PORT_W bits of the write data as the output value of group p. A read of that offset returns it.
- R3: A write to offset 0x04 + 12*p stores the direction of group p (1 = output, 0 = input). The group's output enable bits equal the stored direction from the cycle after the write edge.
- R4: A driven output bit equals the output value bit when its direction bit is 1. It is 0 when its direction bit is 0.
- R5: A read of offset 0x50 + 4*p returns the pins of group p as sampled two clock edges before the end of the access phase (two-flop synchronizer).
- R6: Writes to the pin view offsets are ignored. No register or output changes.
- R7: Register bits at or above PORT_W read as 0, and writing them has no effect.
- R8: Offsets that map to nothing read as 0, and writes to them have no effect. These include 0x08 + 12*p, the offsets of groups at or above NUM_PORTS, and offsets above 0x5C.
- R9: An access to any word offset from 0x30 to 0x4C raises the interrupt-unit select while the bus select is high. During that access the bank's read data is the interrupt unit's read data, and the bank's own registers are not changed.
- R10: A cycle with select and write high but enable low (setup phase) changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | Bus select |
| penable | input | 1 | Access phase indicator |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset, word aligned |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| irq_sel | output | 1 | Select strobe for the interrupt unit's window |
| irq_rdata | input | 32 | Read data returned by the interrupt unit |
| gpio_in | input | NUM_PORTS*PORT_W | Pin levels, group p at bits p*PORT_W upward |
| gpio_out | output | NUM_PORTS*PORT_W | Driven pin values |
| gpio_oe | output | NUM_PORTS*PORT_W | Output enables (1 = driven) |

## Verification
Register writes show up on the pin outputs and in read-back from the first cycle after the edge that closes the access phase. Read data and the interrupt-unit select are combinational during the access phase, so the bench samples them one time unit after the access phase begins. Pin views trail the pins by two edges. The bench keeps a behavioural model with a two-entry history per group and updates it on every rising edge, in step with the design. It compares the pin outputs at every falling edge and compares read data inside each access phase against that model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BUS_W       = 32;
  localparam int MAX_PORTS   = 4;
  localparam int PORT_STRIDE = 12;
  localparam int DIR_OFS     = 4;
  localparam int PIN_BASE    = 'h50;
  localparam int PIN_STRIDE  = 4;
  localparam int IRQ_LO      = 'h30;
  localparam int IRQ_HI      = 'h4C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_PIN,
    SEL_IRQ
  } sel_kind_e;

  typedef struct packed {
    sel_kind_e   kind;
    logic [1:0]  port;
  } reg_sel_t;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_no = stage2_q;
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_PORTS = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_t          sel_o
);
  always_comb begin
    sel_o.kind = SEL_NONE;
    sel_o.port = 2'd0;
    if (addr_i[1:0] == 2'b00) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (addr_i == ADDR_W'(p * PORT_STRIDE)) begin
          sel_o.kind = SEL_DATA;
          sel_o.port = 2'(p);
        end
        if (addr_i == ADDR_W'(p * PORT_STRIDE + DIR_OFS)) begin
          sel_o.kind = SEL_DIR;
          sel_o.port = 2'(p);
        end
        if (addr_i == ADDR_W'(PIN_BASE + p * PIN_STRIDE)) begin
          sel_o.kind = SEL_PIN;
          sel_o.port = 2'(p);
        end
      end
      if ((addr_i >= ADDR_W'(IRQ_LO)) && (addr_i <= ADDR_W'(IRQ_HI))) begin
        sel_o.kind = SEL_IRQ;
        sel_o.port = 2'd0;
      end
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         data_we_i,
  input  logic         dir_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] dir_o
);
  logic [W-1:0] data_q, data_d;
  logic [W-1:0] dir_q,  dir_d;

  always_comb begin
    data_d = data_q;
    dir_d  = dir_q;
    if (data_we_i) data_d = wdata_i;
    if (dir_we_i)  dir_d  = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (data_we_i) begin
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
    end else if (dir_we_i) begin
      dir_q <= dir_d;
    end
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i) begin
    meta_q <= pin_i;
    sync_q <= meta_q;
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                          pclk,
  input  logic                          presetn,
  input  logic                          psel,
  input  logic                          penable,
  input  logic                          pwrite,
  input  logic [ADDR_W-1:0]             paddr,
  input  logic [BUS_W-1:0]              pwdata,
  output logic [BUS_W-1:0]              prdata,
  output logic                          irq_sel,
  input  logic [BUS_W-1:0]              irq_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0]   gpio_in,
  output logic [NUM_PORTS*PORT_W-1:0]   gpio_out,
  output logic [NUM_PORTS*PORT_W-1:0]   gpio_oe
);
  localparam int PINS_W = NUM_PORTS * PORT_W;

  logic              rst_n;
  reg_sel_t          sel;
  logic              wr_acc;
  logic [PORT_W-1:0] wr_word;
  logic [PORT_W-1:0] data_arr [NUM_PORTS];
  logic [PORT_W-1:0] dir_arr  [NUM_PORTS];
  logic [PORT_W-1:0] pin_arr  [NUM_PORTS];
  logic [BUS_W-1:0]  rd_word;

  gpio_rst_sync u_rst (
    .clk_i   (pclk),
    .arst_ni (presetn),
    .rst_no  (rst_n)
  );

  gpio_addr_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_PORTS (NUM_PORTS)
  ) u_dec (
    .addr_i (paddr),
    .sel_o  (sel)
  );

  assign wr_acc  = psel & penable & pwrite;
  assign wr_word = pwdata[PORT_W-1:0];

  if (PORT_W < BUS_W) begin : g_hi_unused
    logic unused_hi;
    assign unused_hi = ^pwdata[BUS_W-1:PORT_W];
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    logic data_we;
    logic dir_we;

    assign data_we = wr_acc && (sel.kind == SEL_DATA) && (sel.port == 2'(g));
    assign dir_we  = wr_acc && (sel.kind == SEL_DIR)  && (sel.port == 2'(g));

    gpio_port_regs #(.W(PORT_W)) u_regs (
      .clk_i     (pclk),
      .rst_ni    (rst_n),
      .data_we_i (data_we),
      .dir_we_i  (dir_we),
      .wdata_i   (wr_word),
      .data_o    (data_arr[g]),
      .dir_o     (dir_arr[g])
    );

    gpio_in_sync #(.W(PORT_W)) u_sync (
      .clk_i  (pclk),
      .pin_i  (gpio_in[g*PORT_W +: PORT_W]),
      .sync_o (pin_arr[g])
    );

    assign gpio_oe[g*PORT_W +: PORT_W]  = dir_arr[g];
    assign gpio_out[g*PORT_W +: PORT_W] = data_arr[g] & dir_arr[g];
  end

  always_comb begin
    rd_word = '0;
    case (sel.kind)
      SEL_DATA: begin
        for (int p = 0; p < NUM_PORTS; p++)
          if (sel.port == 2'(p)) rd_word[PORT_W-1:0] = data_arr[p];
      end
      SEL_DIR: begin
        for (int p = 0; p < NUM_PORTS; p++)
          if (sel.port == 2'(p)) rd_word[PORT_W-1:0] = dir_arr[p];
      end
      SEL_PIN: begin
        for (int p = 0; p < NUM_PORTS; p++)
          if (sel.port == 2'(p)) rd_word[PORT_W-1:0] = pin_arr[p];
      end
      SEL_IRQ:  rd_word = irq_rdata;
      default:  rd_word = '0;
    endcase
  end

  assign prdata  = psel ? rd_word : '0;
  assign irq_sel = psel && (sel.kind == SEL_IRQ);

  if (PINS_W < 1) begin : g_bad_cfg
    logic unused_cfg;
    assign unused_cfg = 1'b0;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32,
  parameter int ADDR_W    = 8
) (
  input logic                        pclk,
  input logic                        presetn,
  input logic                        psel,
  input logic                        penable,
  input logic                        pwrite,
  input logic [ADDR_W-1:0]           paddr,
  input logic [31:0]                 prdata,
  input logic                        irq_sel,
  input logic [NUM_PORTS*PORT_W-1:0] gpio_in,
  input logic [NUM_PORTS*PORT_W-1:0] gpio_out,
  input logic [NUM_PORTS*PORT_W-1:0] gpio_oe
);
  logic [PORT_W-1:0] grp0_pins;
  logic              unused_chk_bits;
  assign grp0_pins       = gpio_in[PORT_W-1:0];
  assign unused_chk_bits = ^gpio_in;

  // R1
  reset_idle_chk: assert property (@(posedge pclk)
    $rose(presetn) |-> (gpio_oe == '0) && (gpio_out == '0));

  // R4
  released_low_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (gpio_out & ~gpio_oe) == '0);

  // R10
  no_write_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
    !(psel && penable && pwrite) |=> $stable(gpio_oe) && $stable(gpio_out));

  // R9
  irq_window_sel_chk: assert property (@(posedge pclk) disable iff (!presetn)
    irq_sel |-> psel);

  // R9
  irq_write_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (irq_sel && penable && pwrite) |=> $stable(gpio_oe) && $stable(gpio_out));

  // R5
  pin_view_lag_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && !pwrite && paddr == ADDR_W'(8'h50))
      |-> prdata == 32'($past(grp0_pins, 2)));

  if (PORT_W < 32) begin : g_hi
    // R7
    upper_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && !irq_sel) |-> prdata[31:PORT_W] == '0);
  end
endmodule

bind gpio_bank gpio_bank_chk #(
  .NUM_PORTS (NUM_PORTS),
  .PORT_W    (PORT_W),
  .ADDR_W    (ADDR_W)
) u_chk (.*);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  localparam int NP = 3;
  localparam int PW = 12;
  localparam int AW = 8;
  localparam logic [31:0] IRQ_WORD = 32'hA5C3_0F96;

  logic              pclk = 1'b0;
  logic              presetn;
  logic              psel, penable, pwrite;
  logic [AW-1:0]     paddr;
  logic [31:0]       pwdata, prdata, irq_rdata;
  logic              irq_sel;
  logic [NP*PW-1:0]  gpio_in, gpio_out, gpio_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit run_chk = 0;

  logic [PW-1:0] m_data [4];
  logic [PW-1:0] m_dir  [4];
  logic [PW-1:0] m_s1   [4];
  logic [PW-1:0] m_s2   [4];
  int            rst_cnt;

  always #10 pclk = ~pclk;

  gpio_bank #(.NUM_PORTS(NP), .PORT_W(PW), .ADDR_W(AW)) uut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .irq_sel(irq_sel), .irq_rdata(irq_rdata), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // reference model: registers (reset released two edges after presetn rises)
  always @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      rst_cnt = 0;
      for (int i = 0; i < 4; i++) begin m_data[i] = '0; m_dir[i] = '0; end
    end else begin
      if (rst_cnt >= 2 && psel && penable && pwrite) begin
        int off;
        off = int'(paddr);
        if (off < 'h30 && (off / 12) < NP) begin
          if (off % 12 == 0) m_data[off / 12] = pwdata[PW-1:0];
          if (off % 12 == 4) m_dir[off / 12]  = pwdata[PW-1:0];
        end
      end
      if (rst_cnt < 2) rst_cnt++;
    end
  end

  // reference model: two-stage pin history
  always @(posedge pclk) begin
    for (int i = 0; i < NP; i++) begin
      m_s2[i] = m_s1[i];
      m_s1[i] = gpio_in[i*PW +: PW];
    end
  end

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    int off;
    off = int'(a);
    exp_read = '0;
    if (off % 4 != 0) return '0;
    if (off < 'h30) begin
      if ((off / 12) < NP && off % 12 == 0) exp_read = 32'(m_data[off / 12]);
      if ((off / 12) < NP && off % 12 == 4) exp_read = 32'(m_dir[off / 12]);
    end else if (off <= 'h4C) begin
      exp_read = irq_rdata;
    end else if (off >= 'h50 && off <= 'h5C) begin
      if ((off - 'h50) / 4 < NP) exp_read = 32'(m_s2[(off - 'h50) / 4]);
    end
  endfunction

  // per-cycle comparison of pin outputs (R1 during reset, R3 and R4 after)
  always @(negedge pclk) begin
    if (run_chk) begin
      logic [63:0] e_oe, e_out;
      e_oe = '0; e_out = '0;
      for (int i = 0; i < NP; i++) begin
        e_oe[i*PW +: PW]  = m_dir[i];
        e_out[i*PW +: PW] = m_data[i] & m_dir[i];
      end
      chk("R3 gpio_oe", 64'(gpio_oe), e_oe);
      chk("R4 gpio_out", 64'(gpio_out), e_out);
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1;
    #1;
    chk({tag, " irq_sel"}, 64'(irq_sel), 64'(a >= 8'h30 && a <= 8'h4C && a[1:0] == 0));
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk);
    penable = 1;
    #1;
    chk(tag, 64'(prdata), 64'(exp_read(a)));
    chk({tag, " irq_sel"}, 64'(irq_sel), 64'(a >= 8'h30 && a <= 8'h4C && a[1:0] == 0));
    @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  initial begin
    #(20ns * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    presetn = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    irq_rdata = IRQ_WORD; gpio_in = '0;
    @(posedge pclk);
    run_chk = 1;
    repeat (3) @(posedge pclk);
    @(negedge pclk) presetn = 1;
    repeat (4) @(posedge pclk);

    // R1: registers clear after reset
    for (int p = 0; p < NP; p++) begin
      rd(AW'(p * 12), "R1 data after reset");
      rd(AW'(p * 12 + 4), "R1 dir after reset");
    end

    // R2, R7: value register with upper bits masked
    wr(8'h00, 32'hFFFF_F5A5, "R2");
    rd(8'h00, "R2 R7 group0 value");
    // R3, R4: direction enables part of the group
    wr(8'h04, 32'h0000_00F0, "R3");
    rd(8'h04, "R3 group0 dir");
    wr(8'h0C, 32'h0000_0ABC, "R2");
    wr(8'h10, 32'hFFFF_FFFF, "R3");
    wr(8'h18, 32'h0000_0123, "R2");
    wr(8'h1C, 32'h0000_0F0F, "R3");
    rd(8'h0C, "R2 group1 value");
    rd(8'h10, "R7 group1 dir all-ones write");
    rd(8'h18, "R2 group2 value");
    rd(8'h1C, "R3 group2 dir");
    rd(8'h00, "R2 group0 unchanged");
    wr(8'h04, 32'h0000_0000, "R4");
    rd(8'h04, "R4 group0 released");

    // R8: holes and absent group
    wr(8'h08, 32'hFFFF_FFFF, "R8");
    wr(8'h24, 32'hFFFF_FFFF, "R8");
    wr(8'h28, 32'hFFFF_FFFF, "R8");
    rd(8'h08, "R8 hole 0x08");
    rd(8'h14, "R8 hole 0x14");
    rd(8'h24, "R8 absent group value");
    rd(8'h28, "R8 absent group dir");
    rd(8'h5C, "R8 absent group pins");
    rd(8'h60, "R8 beyond map");
    rd(8'hFC, "R8 top of map");
    rd(8'h00, "R8 group0 untouched");

    // R9: interrupt window forwarded
    rd(8'h30, "R9 window low");
    rd(8'h40, "R9 window mid");
    irq_rdata = 32'h1357_9BDF;
    rd(8'h4C, "R9 window high");
    wr(8'h34, 32'hFFFF_FFFF, "R9");
    wr(8'h3C, 32'h0000_0000, "R9");
    rd(8'h10, "R9 group1 dir untouched");

    // R5: pin views follow through two stages
    gpio_in = {12'h3C5, 12'h0FF, 12'hA5A};
    rd(8'h50, "R5 group0 pins");
    rd(8'h54, "R5 group1 pins");
    rd(8'h58, "R5 group2 pins");
    @(negedge pclk) gpio_in = {12'h111, 12'hE0E, 12'h5A5};
    rd(8'h50, "R5 group0 pins changed");
    gpio_in = {12'hFFF, 12'hFFF, 12'hFFF};
    rd(8'h54, "R5 group1 pins immediate");
    rd(8'h58, "R5 group2 pins settled");

    // R6: writes to pin views ignored
    wr(8'h50, 32'h0000_0000, "R6");
    wr(8'h54, 32'h0000_0000, "R6");
    rd(8'h50, "R6 pin view still pins");
    rd(8'h00, "R6 group0 value untouched");
    rd(8'h0C, "R6 group1 value untouched");

    // R10: setup-phase-only write has no effect
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 1; paddr = 8'h10; pwdata = 32'h0;
    @(negedge pclk);
    @(negedge pclk);
    psel = 0; pwrite = 0;
    rd(8'h10, "R10 dir after setup-only");

    repeat (3) @(posedge pclk);
    @(negedge pclk);
    run_chk = 0;
    finish_run();
  end
endmodule